// File: doc/BRIEF.md
# Strap-Configured Multiplexed Processor Bus Slave

This block connects an 8-bit microprocessor bus, on which address and data share one set of lines, to a small internal register file. Two strap inputs are read during reset. The first chooses how the two strobe pins are interpreted: as a direction bit plus a data strobe, or as separate active-low read and write strobes. The second chooses how the register address reaches the block: latched on the falling edge of an address latch enable, or written like data while a select line marks the bus cycle as an address cycle.

Each accepted write makes the block busy for a programmable number of clocks, shown on a ready output. Strobes that begin while the block is busy are dropped. Reads drive the data lines through an output-enable that is active only while the accepted read strobe is held. A pending-event register with a mask feeds an interrupt output. Its polarity can be set to active-high or active-low, and it can either hold a level or give a fixed-width pulse.

All bus inputs are assumed to be synchronous to `clk`. Register offsets: 0 control, 1 wait length, 2 pending events, 3 event mask, 4 and up scratch storage.

Top module: `mux_bus_if`

## Requirements
- R1: The strobe-style strap (`strap_style`) and the address-style strap (`strap_addr`) are captured while `rst` is high and keep their values until the next reset, whatever the strap pins do afterwards.
- R2: With `strap_style`=0, a cycle with `cs_n`=0 and `strb_b`=0 is a read when `strb_a`=1 and a write when `strb_a`=0.
- R3: With `strap_style`=1, `strb_a` is an active-low read strobe and `strb_b` is an active-low write strobe, both qualified by `cs_n`=0.
- R4: With `strap_addr`=0, a high-to-low transition of `ale_sel` loads `ad_in` into the address register on that clock.
- R5: With `strap_addr`=1, an accepted write with `ale_sel`=1 loads `ad_in` into the address register, and one with `ale_sel`=0 writes `ad_in` to the addressed register.
- R6: While `cs_n`=1, strobes have no effect: no write, no busy period, no data drive.
- R7: After an accepted write, `ready` is low for exactly N clocks, where N is the value in register 1 (reset value 3). N=0 gives no busy period.
- R8: A strobe whose first active clock falls while `ready` is low is ignored for its whole duration. It neither writes nor drives the bus nor lengthens the busy period.
- R9: `ad_oe` rises one clock after an accepted read strobe is first seen and falls one clock after the strobe ends. While `ad_oe` is high, `ad_out` holds the addressed register as it was on the accept clock.
- R10: Register 0 bit 0 selects active-high interrupt polarity and bit 1 selects level signaling (reset value 0). Register 2 bits are set by `evt_in` pulses and cleared by writing 1; a set wins over a clear on the same clock. Register 3 is the event mask. Registers 4 and up are read/write scratch storage.
- R11: In level signaling, `irq` is active from the clock after a masked-in pending bit is set until the clock after no masked-in pending bit remains.
- R12: In pulse signaling, each pending bit that newly becomes masked-in and set produces an `irq` pulse of exactly PULSE_W clocks (default 4), starting one clock after the event. An event on a bit that is already pending gives no pulse.
- R13: The inactive level of `irq` is low when polarity bit 0 is 1 and high when it is 0, so after reset `irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_style | input | 1 | Strobe-style strap: 0 direction plus data strobe, 1 separate read/write strobes |
| strap_addr | input | 1 | Address-style strap: 0 latch enable, 1 address/data select |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Direction (1 = read) or active-low read strobe |
| strb_b | input | 1 | Active-low data strobe or active-low write strobe |
| ale_sel | input | 1 | Address latch enable or address/data select |
| ad_in | input | DW | Address/data lines as seen by the block |
| evt_in | input | NEVT | One-clock event pulses that set pending bits |
| ad_out | output | DW | Read data for the address/data lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ready | output | 1 | High when the next access can be accepted |
| irq | output | 1 | Interrupt with programmable polarity and signaling |

## Verification
The assertions assume that the bus pins are already synchronous to `clk`. They also assume that a strobe stays active across at least one rising edge, and that `ad_in` and `ale_sel` are stable on the clock where a strobe is first seen. The stimulus meets these assumptions by changing every bus input at the falling clock edge and holding each strobe for a full cycle. Event pulses are driven the same way and last one cycle. The interrupt checks presume that the control register is not rewritten during a pulse. The bench therefore changes polarity or signaling only while no pulse is in flight.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

  typedef enum logic {
    STB_DIR_DS = 1'b0,
    STB_RD_WR  = 1'b1
  } stb_style_e;

  typedef enum logic {
    ADR_LATCH  = 1'b0,
    ADR_SELECT = 1'b1
  } adr_style_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_WAIT = 1;
  localparam int unsigned REG_PEND = 2;
  localparam int unsigned REG_MASK = 3;
  localparam int unsigned REG_SCR0 = 4;

  typedef struct packed {
    logic lvl;
    logic pol_hi;
  } irq_cfg_t;

endpackage

// File: rtl/mbi_strobe_dec.sv
module mbi_strobe_dec
  import mbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_style,
  input  logic       strap_addr,
  input  logic       cs_n,
  input  logic       strb_a,
  input  logic       strb_b,
  input  logic       ale_sel,
  input  logic       ready,
  output stb_style_e style_q,
  output adr_style_e astyle_q,
  output logic       rd_live,
  output logic       rd_accept,
  output logic       wr_accept,
  output logic       wr_is_addr,
  output logic       ale_fall
);

  logic wr_live;
  logic rd_prev, wr_prev, ale_prev;

  // straps follow the pins throughout reset, frozen once reset drops
  always_ff @(posedge clk) begin
    if (rst) begin
      style_q  <= stb_style_e'(strap_style);
      astyle_q <= adr_style_e'(strap_addr);
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      ale_prev <= 1'b0;
    end else begin
      rd_prev  <= rd_live;
      wr_prev  <= wr_live;
      ale_prev <= ale_sel;
    end
  end

  always_comb begin
    if (style_q == STB_DIR_DS) begin
      rd_live = !cs_n && !strb_b && strb_a;
      wr_live = !cs_n && !strb_b && !strb_a;
    end else begin
      rd_live = !cs_n && !strb_a;
      wr_live = !cs_n && !strb_b;
    end
  end

  // only the first active clock of a strobe counts, and only when idle
  assign rd_accept  = rd_live && !rd_prev && ready;
  assign wr_accept  = wr_live && !wr_prev && ready;
  assign wr_is_addr = (astyle_q == ADR_SELECT) && ale_sel;
  assign ale_fall   = (astyle_q == ADR_LATCH) && ale_prev && !ale_sel;

endmodule

// File: rtl/mbi_regfile.sv
module mbi_regfile
  import mbi_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned NEVT    = 4,
  parameter int unsigned LAT_RST = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   ad_in,
  input  logic            ale_fall,
  input  logic            wr_accept,
  input  logic            wr_is_addr,
  input  logic            rd_accept,
  input  logic            rd_live,
  input  logic [NEVT-1:0] evt_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [DW-1:0]   lat_val,
  output irq_cfg_t        cfg,
  output logic [NEVT-1:0] pend,
  output logic [NEVT-1:0] mask
);

  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned NSCR = NREG - REG_SCR0;
  localparam int unsigned SW   = $clog2(NSCR);

  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   scr_off;
  logic [SW-1:0]   scr_idx;
  logic            is_scr;
  logic            dat_wr;
  logic [NEVT-1:0] clr_bits;
  logic [NEVT-1:0] pend_n;
  logic [DW-1:0]   reg_word;
  logic [DW-1:0]   reg_q;
  logic [DW-1:0]   scr_q;
  logic            scr_sel_q;
  logic [DW-1:0]   scr_mem [NSCR];

  assign scr_off = addr_q - AW'(REG_SCR0);
  assign scr_idx = scr_off[SW-1:0];
  assign is_scr  = (addr_q >= AW'(REG_SCR0));
  assign dat_wr  = wr_accept && !wr_is_addr;

  assign clr_bits = (dat_wr && addr_q == AW'(REG_PEND)) ? ad_in[NEVT-1:0] : '0;
  assign pend_n   = (pend & ~clr_bits) | evt_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      cfg     <= '0;
      lat_val <= DW'(LAT_RST);
      mask    <= '0;
      pend    <= '0;
    end else begin
      pend <= pend_n;
      if (ale_fall || (wr_accept && wr_is_addr)) begin
        addr_q <= ad_in[AW-1:0];
      end
      if (dat_wr) begin
        case (addr_q)
          AW'(REG_CTRL): cfg     <= irq_cfg_t'(ad_in[1:0]);
          AW'(REG_WAIT): lat_val <= ad_in;
          AW'(REG_MASK): mask    <= ad_in[NEVT-1:0];
          default: ;
        endcase
      end
    end
  end

  // scratch storage: plain write port and registered read for RAM inference
  always_ff @(posedge clk) begin
    if (dat_wr && is_scr) begin
      scr_mem[scr_idx] <= ad_in;
    end
    if (rd_accept) begin
      scr_q <= scr_mem[scr_idx];
    end
  end

  always_comb begin
    case (addr_q)
      AW'(REG_CTRL): reg_word = DW'(cfg);
      AW'(REG_WAIT): reg_word = lat_val;
      AW'(REG_PEND): reg_word = DW'(pend);
      AW'(REG_MASK): reg_word = DW'(mask);
      default:       reg_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      scr_sel_q <= 1'b0;
      ad_oe     <= 1'b0;
    end else begin
      if (rd_accept) begin
        reg_q     <= reg_word;
        scr_sel_q <= is_scr;
        ad_oe     <= 1'b1;
      end else if (!rd_live) begin
        ad_oe <= 1'b0;
      end
    end
  end

  assign ad_out = scr_sel_q ? scr_q : reg_q;

endmodule

// File: rtl/mbi_ready.sv
module mbi_ready #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_accept,
  input  logic [DW-1:0] lat_val,
  output logic          ready,
  output logic [DW-1:0] busy_cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      busy_cnt <= '0;
    end else if (wr_accept) begin
      if (lat_val == '0) begin
        ready <= 1'b1;
      end else begin
        ready    <= 1'b0;
        busy_cnt <= lat_val;
      end
    end else if (!ready) begin
      if (busy_cnt <= DW'(1)) begin
        ready    <= 1'b1;
        busy_cnt <= '0;
      end else begin
        busy_cnt <= busy_cnt - DW'(1);
      end
    end
  end

endmodule

// File: rtl/mbi_irq.sv
module mbi_irq
  import mbi_pkg::*;
#(
  parameter int unsigned NEVT    = 4,
  parameter int unsigned PULSE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  irq_cfg_t        cfg,
  input  logic [NEVT-1:0] pend,
  input  logic [NEVT-1:0] mask,
  output logic            irq
);

  localparam int unsigned PCW = $clog2(PULSE_W + 1);

  logic [NEVT-1:0] pm, pm_q;
  logic            new_ev;
  logic            act;
  logic [PCW-1:0]  pcnt;

  assign pm     = pend & mask;
  assign new_ev = |(pm & ~pm_q);
  assign act    = cfg.lvl ? (|pm) : (new_ev || pcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q <= '0;
      pcnt <= '0;
      irq  <= 1'b1;
    end else begin
      pm_q <= pm;
      if (new_ev) begin
        pcnt <= PCW'(PULSE_W - 1);
      end else if (pcnt != '0) begin
        pcnt <= pcnt - PCW'(1);
      end
      irq <= cfg.pol_hi ? act : !act;
    end
  end

endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
  import mbi_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned NEVT    = 4,
  parameter int unsigned LAT_RST = 3,
  parameter int unsigned PULSE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_style,
  input  logic            strap_addr,
  input  logic            cs_n,
  input  logic            strb_a,
  input  logic            strb_b,
  input  logic            ale_sel,
  input  logic [DW-1:0]   ad_in,
  input  logic [NEVT-1:0] evt_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            ready,
  output logic            irq
);

  stb_style_e      style_q;
  adr_style_e      astyle_q;
  logic            rd_live, rd_accept, wr_accept, wr_is_addr, ale_fall;
  logic [DW-1:0]   lat_val;
  logic [DW-1:0]   busy_cnt;
  irq_cfg_t        cfg;
  logic [NEVT-1:0] pend, mask, pm_vec;

  assign pm_vec = pend & mask;

  mbi_strobe_dec u_dec (
    .clk        (clk),
    .rst        (rst),
    .strap_style(strap_style),
    .strap_addr (strap_addr),
    .cs_n       (cs_n),
    .strb_a     (strb_a),
    .strb_b     (strb_b),
    .ale_sel    (ale_sel),
    .ready      (ready),
    .style_q    (style_q),
    .astyle_q   (astyle_q),
    .rd_live    (rd_live),
    .rd_accept  (rd_accept),
    .wr_accept  (wr_accept),
    .wr_is_addr (wr_is_addr),
    .ale_fall   (ale_fall)
  );

  mbi_regfile #(
    .DW(DW), .AW(AW), .NEVT(NEVT), .LAT_RST(LAT_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ad_in     (ad_in),
    .ale_fall  (ale_fall),
    .wr_accept (wr_accept),
    .wr_is_addr(wr_is_addr),
    .rd_accept (rd_accept),
    .rd_live   (rd_live),
    .evt_in    (evt_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .lat_val   (lat_val),
    .cfg       (cfg),
    .pend      (pend),
    .mask      (mask)
  );

  mbi_ready #(.DW(DW)) u_rdy (
    .clk      (clk),
    .rst      (rst),
    .wr_accept(wr_accept),
    .lat_val  (lat_val),
    .ready    (ready),
    .busy_cnt (busy_cnt)
  );

  mbi_irq #(.NEVT(NEVT), .PULSE_W(PULSE_W)) u_irq (
    .clk (clk),
    .rst (rst),
    .cfg (cfg),
    .pend(pend),
    .mask(mask),
    .irq (irq)
  );

endmodule

// File: rtl/mbi_chk.sv
module mbi_chk #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NEVT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            ready,
  input logic            ad_oe,
  input logic            irq,
  input logic            style_q,
  input logic            astyle_q,
  input logic            cfg_lvl,
  input logic            cfg_pol,
  input logic [NEVT-1:0] pm_vec,
  input logic [DW-1:0]   busy_cnt
);

  assert_straps_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(style_q) && $stable(astyle_q)));

  assert_oe_needs_cs_R9: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(!cs_n));

  assert_oe_not_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(ready));

  assert_busy_from_access_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(!cs_n));

  assert_ready_idle_count_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> (busy_cnt == '0));

  assert_level_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_lvl && pm_vec == '0) |=> (irq == !$past(cfg_pol)));

endmodule

bind mux_bus_if mbi_chk #(.DW(DW), .NEVT(NEVT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .ready   (ready),
  .ad_oe   (ad_oe),
  .irq     (irq),
  .style_q (style_q),
  .astyle_q(astyle_q),
  .cfg_lvl (cfg.lvl),
  .cfg_pol (cfg.pol_hi),
  .pm_vec  (pm_vec),
  .busy_cnt(busy_cnt)
);

// File: tb/tb_mux_bus_if.sv
module tb_mux_bus_if;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NEVT = 4;
  localparam int PULSE_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_style = 1'b0, strap_addr = 1'b0;
  logic cs_n = 1'b1, strb_a = 1'b1, strb_b = 1'b1, ale_sel = 1'b0;
  logic [DW-1:0] ad_in = '0;
  logic [NEVT-1:0] evt_in = '0;
  logic [DW-1:0] ad_out;
  logic ad_oe, ready, irq;

  int total = 0;
  int bad = 0;
  bit cur_style, cur_astyle;
  logic [7:0] mdl [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_if dut (
    .clk(clk), .rst(rst), .strap_style(strap_style), .strap_addr(strap_addr),
    .cs_n(cs_n), .strb_a(strb_a), .strb_b(strb_b), .ale_sel(ale_sel),
    .ad_in(ad_in), .evt_in(evt_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .ready(ready), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulse_count(input bit already_pending);
    return already_pending ? 0 : PULSE_W;
  endfunction

  task automatic idle_bus();
    cs_n = 1'b1; strb_a = 1'b1; strb_b = 1'b1;
  endtask

  task automatic do_reset(input bit st, input bit as);
    @(negedge clk);
    rst = 1'b1; strap_style = st; strap_addr = as;
    idle_bus(); ale_sel = 1'b0; evt_in = '0;
    cur_style = st; cur_astyle = as;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // straps moved away after reset: must not matter (R1)
    strap_style = !st; strap_addr = !as;
  endtask

  task automatic drive_write(input bit sel, input logic [7:0] d);
    cs_n = 1'b0; ad_in = d;
    if (cur_astyle) ale_sel = sel;
    if (cur_style) begin strb_a = 1'b1; strb_b = 1'b0; end
    else begin strb_a = 1'b0; strb_b = 1'b0; end
  endtask

  task automatic drive_read();
    cs_n = 1'b0;
    if (cur_style) begin strb_a = 1'b0; strb_b = 1'b1; end
    else begin strb_a = 1'b1; strb_b = 1'b0; end
  endtask

  task automatic wait_ready(output int lc);
    lc = 0;
    while (!ready && lc < 1000) begin
      lc++;
      @(posedge clk); #1;
    end
  endtask

  task automatic bus_write(input bit sel, input logic [7:0] d, output int lc);
    @(negedge clk);
    drive_write(sel, d);
    @(posedge clk); #1;
    idle_bus();
    wait_ready(lc);
  endtask

  task automatic set_addr(input logic [7:0] a);
    int lc;
    if (!cur_astyle) begin
      @(negedge clk); ale_sel = 1'b1; ad_in = a;
      @(negedge clk); ale_sel = 1'b0;
      @(posedge clk); #1;
    end else begin
      bus_write(1'b1, a, lc);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output int lc);
    set_addr(a);
    bus_write(1'b0, d, lc);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d,
                         output bit oe_on, output bit oe_off);
    set_addr(a);
    @(negedge clk);
    drive_read();
    @(posedge clk); #1;
    oe_on = ad_oe; d = ad_out;
    @(negedge clk);
    idle_bus();
    @(posedge clk); #1;
    oe_off = ad_oe;
  endtask

  task automatic fire_event(input int b);
    @(negedge clk); evt_in = NEVT'(1 << b);
    @(negedge clk); evt_in = '0;
  endtask

  task automatic count_active(input bit pol_hi, output int n);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      if (irq == pol_hi) n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lc;
    int n;
    logic [7:0] d;
    bit oe1, oe0;
    string tag;
    void'($urandom(32'h5eed_1234));

    // four strap combinations: strobe style x address style
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1]);
      tag = m[0] ? "R3" : "R2";
      @(posedge clk); #1;
      chk(ready == 1'b1 && ad_oe == 1'b0, "R1 reset ready/oe", {ready, ad_oe}, 2);
      chk(irq == 1'b1, "R13 reset irq idle high", irq, 1);
      for (int a = 4; a < 8; a++) begin
        mdl[a] = 8'($urandom);
        do_write(8'(a), mdl[a], lc);
        chk(lc == 3, "R7 reset wait length", lc, 3);
      end
      for (int a = 4; a < 8; a++) begin
        do_read(8'(a), d, oe1, oe0);
        chk(d == mdl[a], m[1] ? "R5 select readback" : "R4 latch readback", d, mdl[a]);
        chk(oe1 == 1'b1 && oe0 == 1'b0, "R9 oe window", {oe1, oe0}, 2);
      end
      for (int k = 0; k < 20; k++) begin
        int a;
        a = 4 + int'($urandom % 4);
        if ($urandom % 2 == 0) begin
          mdl[a] = 8'($urandom);
          do_write(8'(a), mdl[a], lc);
        end else begin
          do_read(8'(a), d, oe1, oe0);
          chk(d == mdl[a], tag, d, mdl[a]);
        end
      end
    end

    // directed: separate strobes, latch-enable addressing
    do_reset(1'b1, 1'b0);
    for (int a = 4; a < 8; a++) begin
      mdl[a] = 8'(a * 16 + 3);
      do_write(8'(a), mdl[a], lc);
    end

    // R6: strobe with chip select high
    set_addr(8'd5);
    @(negedge clk); cs_n = 1'b1; strb_b = 1'b0; ad_in = 8'hEE;
    @(posedge clk); #1;
    chk(ready == 1'b1, "R6 no busy with cs high", ready, 1);
    @(negedge clk); idle_bus();
    @(negedge clk); cs_n = 1'b1; strb_a = 1'b0;
    @(posedge clk); #1;
    chk(ad_oe == 1'b0, "R6 no drive with cs high", ad_oe, 0);
    @(negedge clk); idle_bus();
    do_read(8'd5, d, oe1, oe0);
    chk(d == mdl[5], "R6 value untouched", d, mdl[5]);

    // R7: programmed wait lengths
    do_write(8'd1, 8'd6, lc);
    do_write(8'd6, 8'h5A, lc); mdl[6] = 8'h5A;
    chk(lc == 6, "R7 wait length 6", lc, 6);
    do_write(8'd1, 8'd0, lc);
    do_write(8'd7, 8'h77, lc); mdl[7] = 8'h77;
    chk(lc == 0, "R7 wait length 0", lc, 0);
    do_read(8'd1, d, oe1, oe0);
    chk(d == 8'd0, "R10 wait register readback", d, 0);
    do_write(8'd1, 8'd6, lc);

    // R8: strobes that start during busy
    set_addr(8'd4);
    @(negedge clk); drive_write(1'b0, 8'h22);
    @(posedge clk); #1; idle_bus();
    @(negedge clk); drive_read();
    @(posedge clk); #1;
    chk(ad_oe == 1'b0, "R8 read ignored when busy", ad_oe, 0);
    @(negedge clk); idle_bus();
    @(negedge clk); drive_write(1'b0, 8'h33);
    @(posedge clk); #1; idle_bus();
    n = 3;
    wait_ready(lc);
    chk(lc + n == 6, "R8 busy not lengthened", lc + n, 6);
    mdl[4] = 8'h22;
    do_read(8'd4, d, oe1, oe0);
    chk(d == 8'h22, "R8 write ignored when busy", d, 8'h22);
    do_write(8'd1, 8'd2, lc);

    // R10/R11/R13: level mode, active high
    do_write(8'd3, 8'h01, lc);
    do_write(8'd0, 8'h03, lc);
    @(posedge clk); #1;
    chk(irq == 1'b0, "R13 active-high idle low", irq, 0);
    fire_event(0);
    @(posedge clk); #1;
    chk(irq == 1'b1, "R11 level asserted", irq, 1);
    fire_event(1);
    do_read(8'd2, d, oe1, oe0);
    chk(d == 8'h03, "R10 pending bits", d, 3);
    do_write(8'd2, 8'h01, lc);
    chk(irq == 1'b0, "R11 level released after clear", irq, 0);
    do_read(8'd2, d, oe1, oe0);
    chk(d == 8'h02, "R10 write-one-to-clear", d, 2);
    do_write(8'd2, 8'h02, lc);

    // R12/R13: pulse mode, active low
    do_write(8'd0, 8'h00, lc);
    @(posedge clk); #1;
    chk(irq == 1'b1, "R13 active-low idle high", irq, 1);
    fire_event(0);
    count_active(1'b0, n);
    chk(n == exp_pulse_count(1'b0), "R12 pulse width", n, exp_pulse_count(1'b0));
    fire_event(0);
    count_active(1'b0, n);
    chk(n == exp_pulse_count(1'b1), "R12 no pulse when already pending", n, 0);
    fire_event(2);
    count_active(1'b0, n);
    chk(n == 0, "R12 masked event no pulse", n, 0);
    do_write(8'd2, 8'h0F, lc);
    do_write(8'd0, 8'h01, lc);
    fire_event(0);
    count_active(1'b1, n);
    chk(n == exp_pulse_count(1'b0), "R12 pulse active high", n, PULSE_W);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule